// File: doc/BRIEF.md
# Four-Channel Rotating Router and Sample Reorderer

This block time-shares four analog channels among four input signals. It steps a routing matrix through four cyclic-shift positions. In position k, input i travels on channel (i+k) mod 4. Over one full rotation, every input passes through every channel, so per-channel gain and crosstalk average out. Each position is held for the same number of valid samples. As a result, the switching disturbance appears only at the rotation rate and its harmonics. A shorter hold gives a higher rotation rate and therefore a wider usable bandwidth.

On the digitized side, the block undoes the rotation. It always presents the four signals in the fixed order a, b, c, d, whichever channel carried each one. The routing code, the reordering multiplexers and the correction sub-page index all change on the same clock cycle. A one-cycle strobe marks that cycle, so downstream correction tables can follow the routing state.

The hold length is sampled only when the rotation wraps from position 3 back to 0. A hold length of zero parks the rotation.

Top module: `chan_rotator`

## Requirements
- R1: During and right after reset, `subPage` is 0, `routeSel` carries the identity code 8'hE4, `switchStb` is 0 and `sigOut` is all zero.
- R2: In position k, bits [2c+1:2c] of `routeSel` hold the index of the input routed to channel c, which is (c - k) mod 4.
- R3: Positions advance 0, 1, 2, 3, 0 and so on. Each move increments `subPage` by exactly one, modulo 4.
- R4: Once a hold length D (D > 0) is active, each position is used for exactly D valid samples. Cycles with `sampleValid` low do not count toward D.
- R5: `switchStb` is high for exactly the cycles in which `subPage` and `routeSel` show a new position. Outside those cycles the position does not change.
- R6: On each cycle with `sampleValid` high in position k, `sigOut[i]` (index 0 = a, 1 = b, 2 = c, 3 = d) takes `adcCh[(i+k) mod 4]` on the next cycle. While `sampleValid` is low, `sigOut` holds its value.
- R7: A new value on `dwellLen` takes effect only at the move from position 3 to position 0. Writes made in the middle of a rotation do not alter the current hold length.
- R8: A hold length of zero parks the block in its current position with no moves. While parked, and on the first valid sample after reset, each valid sample loads `dwellLen` and restarts the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rstN | input | 1 | Synchronous active-low reset |
| sampleValid | input | 1 | Marks a cycle that carries a new sample on every channel |
| dwellLen | input | DWELL_W | Requested hold length per position, in valid samples |
| adcCh | input | 4 x SAMPLE_W | Digitized channel samples, channel 0 in the low slice |
| routeSel | output | 8 | Routing code sent to the analog matrix, 2 bits per channel |
| sigOut | output | 4 x SAMPLE_W | Reordered signals; slice 0 = a, 1 = b, 2 = c, 3 = d |
| subPage | output | 2 | Current position index, used as the correction sub-page |
| switchStb | output | 1 | One-cycle mark on the cycle a new position takes effect |

## Verification
The hardest cases to reach are the ones at the 3-to-0 wrap. There, a pending hold-length write must land, and a zero length must park the rotation. Both happen only after several full rotations and only if the write falls at the right moment.

The stimulus handles this in steps. It changes `dwellLen` in the middle of a rotation and runs on across the wrap. It then requests zero just before a wrap, stays parked while `dwellLen` varies, and resumes. It also runs a hold length of one with continuous valids, so that a move happens on every sample.

A reference model in the bench predicts position, strobe, route code and reordered samples for each cycle. Irregular valid gaps check that idle cycles neither count toward the hold nor disturb the outputs.

// File: rtl/chan_rot_pkg.sv
`timescale 1ns/1ps
package chan_rot_pkg;
  localparam int NCH   = 4;
  localparam int POS_W = $clog2(NCH);

  // Strobes and state passed from the sequencer to the datapath
  typedef struct packed {
    logic             sampleEn;
    logic [POS_W-1:0] pos;
  } rotCtl_t;
endpackage

// File: rtl/rot_control.sv
`timescale 1ns/1ps
module rot_control
  import chan_rot_pkg::*;
#(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [DWELL_W-1:0] dwellLen,
  output rotCtl_t            ctl,
  output logic               switchStb
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NCH - 1);

  logic [POS_W-1:0]   posQ;
  logic [DWELL_W-1:0] dwellCnt;
  logic [DWELL_W-1:0] activeDwell;
  logic               parked;
  logic               dwellDone;

  assign parked    = (activeDwell == '0);
  assign dwellDone = !parked && (dwellCnt == activeDwell - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ        <= '0;
      dwellCnt    <= '0;
      activeDwell <= '0;
      switchStb   <= 1'b0;
    end else begin
      switchStb <= 1'b0;
      if (sampleValid) begin
        if (parked) begin
          activeDwell <= dwellLen;
          dwellCnt    <= '0;
        end else if (dwellDone) begin
          dwellCnt  <= '0;
          posQ      <= posQ + 1'b1;
          switchStb <= 1'b1;
          if (posQ == LAST_POS) activeDwell <= dwellLen;
        end else begin
          dwellCnt <= dwellCnt + 1'b1;
        end
      end
    end
  end

  assign ctl.sampleEn = sampleValid;
  assign ctl.pos      = posQ;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    switchStb |-> (posQ == POS_W'($past(posQ) + 1'b1))); // R3
  AST_POS_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rstN)
    !switchStb |-> $stable(posQ)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !parked |-> (dwellCnt < activeDwell)); // R4
  AST_MOVE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    switchStb |-> $past(sampleValid)); // R4
  AST_PARKED_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    parked |=> !switchStb); // R8
endmodule

// File: rtl/rot_datapath.sv
`timescale 1ns/1ps
module rot_datapath
  import chan_rot_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rotCtl_t                       ctl,
  input  logic [NCH-1:0][SAMPLE_W-1:0]  adcCh,
  output logic [NCH*POS_W-1:0]          routeSel,
  output logic [NCH-1:0][SAMPLE_W-1:0]  sigOut
);
  for (genvar c = 0; c < NCH; c++) begin : g_route
    // channel c carries input (c - pos) mod NCH
    assign routeSel[c*POS_W +: POS_W] = POS_W'(c) - ctl.pos;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_demap
    logic [POS_W-1:0] srcCh;
    assign srcCh = POS_W'(i) + ctl.pos;
    always_ff @(posedge clk) begin
      if (!rstN)             sigOut[i] <= '0;
      else if (ctl.sampleEn) sigOut[i] <= adcCh[srcCh];
    end
  end

  AST_A_FROM_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.sampleEn) |-> (sigOut[0] == $past(adcCh[ctl.pos]))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.sampleEn) |-> $stable(sigOut)); // R6
endmodule

// File: rtl/chan_rotator.sv
`timescale 1ns/1ps
module chan_rotator
  import chan_rot_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DWELL_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sampleValid,
  input  logic [DWELL_W-1:0]            dwellLen,
  input  logic [NCH-1:0][SAMPLE_W-1:0]  adcCh,
  output logic [NCH*POS_W-1:0]          routeSel,
  output logic [NCH-1:0][SAMPLE_W-1:0]  sigOut,
  output logic [POS_W-1:0]              subPage,
  output logic                          switchStb
);
  rotCtl_t ctl;

  rot_control #(.DWELL_W(DWELL_W)) u_control (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .dwellLen(dwellLen), .ctl(ctl), .switchStb(switchStb)
  );

  rot_datapath #(.SAMPLE_W(SAMPLE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adcCh(adcCh),
    .routeSel(routeSel), .sigOut(sigOut)
  );

  assign subPage = ctl.pos;

  AST_RESET_IDENTITY: assert property (@(posedge clk)
    !rstN |=> (subPage == '0 && !switchStb)); // R1
endmodule

// File: tb/test_chan_rotator.sv
`timescale 1ns/1ps
module test_chan_rotator;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [15:0]       dwellLen = '0;
  logic [3:0][15:0]  adcCh = '0;
  logic [7:0]        routeSel;
  logic [3:0][15:0]  sigOut;
  logic [1:0]        subPage;
  logic              switchStb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chan_rotator i_chan_rotator (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .dwellLen(dwellLen),
    .adcCh(adcCh), .routeSel(routeSel), .sigOut(sigOut),
    .subPage(subPage), .switchStb(switchStb)
  );

  typedef struct {
    logic [1:0]       pos;
    logic             stb;
    logic [7:0]       route;
    logic [3:0][15:0] out;
    string            tag;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [1:0]       mPos = '0;
  logic [15:0]      mCnt = '0;
  logic [15:0]      mDw  = '0;
  logic [3:0][15:0] mOut = '0;

  function automatic logic [7:0] routeFor(input logic [1:0] k);
    logic [7:0] r;
    for (int c = 0; c < 4; c++) r[c*2 +: 2] = 2'(c) - k;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] dl, input string tag);
    logic [3:0][15:0] a;
    logic stb;
    exp_t e;
    @(negedge clk);
    for (int i = 0; i < 4; i++) a[i] = 16'($urandom);
    sampleValid = v; dwellLen = dl; adcCh = a;
    stb = 1'b0;
    if (v) begin
      for (int i = 0; i < 4; i++) mOut[i] = a[2'(i) + mPos];
      if (mDw == 0) begin
        mDw = dl; mCnt = 0;
      end else if (mCnt == mDw - 1) begin
        mCnt = 0;
        if (mPos == 2'd3) mDw = dl;
        mPos = mPos + 2'd1;
        stb = 1'b1;
      end else begin
        mCnt = mCnt + 1;
      end
    end
    e.pos = mPos; e.stb = stb; e.route = routeFor(mPos); e.out = mOut; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one expected item per cycle, compared after the edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.tag, " R3 subPage"},  64'(subPage),   64'(e.pos));
      check({e.tag, " R5 switchStb"}, 64'(switchStb), 64'(e.stb));
      check({e.tag, " R2 routeSel"}, 64'(routeSel),  64'(e.route));
      check({e.tag, " R6 sigOut"},   64'(sigOut),    64'(e.out));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 subPage", 64'(subPage), 64'd0);
    check("R1 routeSel", 64'(routeSel), 64'hE4);
    check("R1 switchStb", 64'(switchStb), 64'd0);
    check("R1 sigOut", 64'(sigOut), 64'd0);
    rstN = 1'b1;
    // R4/R3: hold of 3, continuous valid, two rotations
    for (int n = 0; n < 26; n++) step(1'b1, 16'd3, "R4 steady");
    // R4/R6: irregular valid gaps
    for (int n = 0; n < 40; n++) step(1'($urandom % 3 != 0), 16'd3, "R4 gaps");
    // R7: mid-rotation write of 5, takes effect only at the wrap
    for (int n = 0; n < 60; n++) step(1'b1, 16'd5, "R7 late length");
    // R5: hold of 1, a move on every sample
    for (int n = 0; n < 30; n++) step(1'b1, 16'd1, "R5 fast");
    // R8: zero requested, park at the wrap, then resume
    for (int n = 0; n < 30; n++) step(1'b1, 16'd0, "R8 park");
    for (int n = 0; n < 6; n++) step(1'($urandom % 2), 16'd0, "R8 parked idle");
    for (int n = 0; n < 20; n++) step(1'b1, 16'd2, "R8 resume");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule